// File: doc/BRIEF.md
# Queued Command FIS Issuer

This block sits between a host's command queue and the framed transmit and receive ports of a serial storage link. Software marks any of 32 command slots as pending through a set-only issue vector. For each pending slot the block reads that slot's command frame, a fixed number of 32-bit words, from a synchronous table RAM. It then sends the words as one frame on an active-low framed transmit port. A slot's pending bit drops only once its last word has been accepted with end-of-frame.

The receive port is always ready to take frames from the device, even while a command is being sent. Two frame kinds are kept, chosen by the low byte of the first word. A 0x41 frame goes to dword offset 0 of the received-frame RAM. A 0x34 frame goes to dword offset 16, which is byte offset 0x40. Frames of any other kind are dropped. When a 0x41 frame ends, the tag in bits 4:0 of its second word is reported as the slot whose data moves next, together with a one-cycle start pulse for the data sequencer.

The device always has priority on the link. If a device frame starts, or the target aborts, while a command frame is still in flight, the block pulses its own abort and withdraws the frame. It then waits until the incoming frame has ended and sends the same slot again from its first word.

Top module: `ncq_fis_issuer`

## Requirements
- R1: While reset is high and in the first cycle after it, `issue_pend` is 0, `tx_valid_n`, `tx_eof_n` and `tx_abort_n` are 1, and `rfis_we` and `dma_start` are 0.
- R2: A 1 on bit i of `issue_set` sets bit i of `issue_pend` at the next clock. That bit clears only after the slot's last word has been accepted with `tx_eof_n`=0 and `tx_tgt_abort_n`=1, and with no receive start-of-frame in the same cycle.
- R3: When several slots are pending, the lowest-numbered slot is sent next.
- R4: A command frame is FIS_DW (5) words. Word k of slot s is read from `tbl_addr` = {s, k}, with 3 bits for k. `tx_eof_n` is low only with word 4. A word and its framing are held until `tx_ready_n` is low.
- R5: A collision is a receive start-of-frame beat (`rx_valid_n`=0 and `rx_sof_n`=0), or `tx_tgt_abort_n`=0, while a frame is being fetched or sent. After a collision `tx_abort_n` is low for exactly the next cycle, and `tx_valid_n` goes high.
- R6: After a collision, the same slot is sent again from word 0 once no device frame is in progress. The slot produces exactly one complete frame.
- R7: `rx_ready_n` is 1 during reset and 0 at all other times, including while a command is being sent.
- R8: A receive frame whose first word has low byte 0x41 is written from dword 0 of the received-frame RAM. One with low byte 0x34 is written from dword 16. Word k is written at base+k, one cycle after its beat, and only the first 8 words are kept. Frames of any other type write nothing.
- R9: At the end-of-frame beat of a 0x41 frame of at least 2 words, `dma_start` is high for one cycle, one cycle after that beat. At the same time `dma_slot` shows bits 4:0 of the frame's second word.
- R10: A cycle with `rx_disc_n`=0 ends the current receive frame. That beat and any later beats without start-of-frame write nothing, and the frame raises no `dma_start`.
- R11: No command frame starts, or restarts, while a device frame is in progress. `tx_valid_n` stays 1 until that frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_set | input | 32 | One-cycle pulses that mark slots pending |
| issue_pend | output | 32 | Pending-slot bitmap |
| tbl_addr | output | 8 | Table RAM word address {slot, word} |
| tbl_data | input | 32 | Table RAM read data, one cycle after the address |
| tx_data | output | 32 | Transmit word |
| tx_valid_n | output | 1 | Transmit word valid, active low |
| tx_eof_n | output | 1 | Transmit end of frame, active low |
| tx_abort_n | output | 1 | Host abort of the current frame, active low |
| tx_ready_n | input | 1 | Target ready, active low |
| tx_tgt_abort_n | input | 1 | Target abort, active low |
| rx_data | input | 32 | Receive word |
| rx_sof_n | input | 1 | Receive start of frame, active low |
| rx_eof_n | input | 1 | Receive end of frame, active low |
| rx_valid_n | input | 1 | Receive word valid, active low |
| rx_disc_n | input | 1 | Receive disconnect from the link, active low |
| rx_ready_n | output | 1 | Receive ready, active low |
| rfis_we | output | 1 | Received-frame RAM write enable |
| rfis_addr | output | 6 | Received-frame RAM dword address |
| rfis_wdata | output | 32 | Received-frame RAM write data |
| dma_start | output | 1 | One-cycle start for the data sequencer |
| dma_slot | output | 5 | Slot tag taken from the last DMA setup frame |

## Verification
Received-frame writes, `dma_start` and `tx_abort_n` all come from registers. Each is due in the cycle after the clock edge that takes its receive beat or collision, so the bench drives each beat on a falling edge and samples 1 ns after the next rising edge. A command's first word shows on `tx_valid_n` two cycles after the edge that selects the slot, because one table read lies in between. The bench therefore does not predict the exact transmit cycle: a falling-edge monitor records every accepted word and rebuilds whole frames, discarding partial ones after an abort. The checks then compare the order of the slots sent and the contents of each word.

// File: rtl/ncq_fis_issuer.sv
module ncq_fis_issuer #(
  parameter int SLOTS     = 32,
  parameter int FIS_DW    = 5,
  parameter int RFIS_AW   = 6,
  parameter int REGION_DW = 8,
  parameter int D2H_BASE  = 16
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [SLOTS-1:0]                          issue_set,
  output logic [SLOTS-1:0]                          issue_pend,
  output logic [$clog2(SLOTS)+$clog2(FIS_DW)-1:0]   tbl_addr,
  input  logic [31:0]                               tbl_data,
  output logic [31:0]                               tx_data,
  output logic                                      tx_valid_n,
  output logic                                      tx_eof_n,
  output logic                                      tx_abort_n,
  input  logic                                      tx_ready_n,
  input  logic                                      tx_tgt_abort_n,
  input  logic [31:0]                               rx_data,
  input  logic                                      rx_sof_n,
  input  logic                                      rx_eof_n,
  input  logic                                      rx_valid_n,
  input  logic                                      rx_disc_n,
  output logic                                      rx_ready_n,
  output logic                                      rfis_we,
  output logic [RFIS_AW-1:0]                        rfis_addr,
  output logic [31:0]                               rfis_wdata,
  output logic                                      dma_start,
  output logic [$clog2(SLOTS)-1:0]                  dma_slot
);
  localparam int SW = $clog2(SLOTS);
  localparam int WW = $clog2(FIS_DW);
  localparam int RW = $clog2(REGION_DW + 1);
  localparam logic [7:0] TYP_DSET = 8'h41;
  localparam logic [7:0] TYP_D2H  = 8'h34;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND, S_WAIT} st_t;
  typedef enum logic [1:0] {K_NONE, K_DSET, K_D2H} kind_t;

  function automatic kind_t kind_of(input logic [7:0] t);
    case (t)
      TYP_DSET: return K_DSET;
      TYP_D2H:  return K_D2H;
      default:  return K_NONE;
    endcase
  endfunction

  st_t             st;
  logic [SLOTS-1:0] pend;
  logic [SW-1:0]   cur;
  logic [WW-1:0]   widx;
  logic            abort_q;

  logic            rx_busy;
  kind_t           rx_kind;
  logic [RW-1:0]   rx_idx;
  logic            tag_ok;
  logic [SW-1:0]   tag;

  logic [SW-1:0]   pick;
  logic            any;
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (pend[i]) begin
        pick = SW'(i);
        any  = 1'b1;
      end
  end

  wire rx_beat     = !rx_valid_n;
  wire rx_sof_beat = rx_beat && !rx_sof_n;
  wire rx_eof_beat = rx_beat && !rx_eof_n;
  wire rx_drop     = !rx_disc_n;
  wire rx_quiet    = !rx_busy && !rx_sof_beat;

  wire   in_frame = rx_sof_beat || rx_busy;
  wire   take     = rx_beat && in_frame && !rx_drop;
  kind_t kind_now;
  assign kind_now = rx_sof_beat ? kind_of(rx_data[7:0]) : rx_kind;
  wire [RW-1:0] idx_now = rx_sof_beat ? '0 : rx_idx;
  wire store   = take && (kind_now != K_NONE) && (idx_now < RW'(REGION_DW));
  wire tag_hit = take && (kind_now == K_DSET) && (idx_now == RW'(1));
  wire tag_eff = tag_hit || (tag_ok && !rx_sof_beat);
  wire fire    = take && rx_eof_beat && (kind_now == K_DSET) && tag_eff;
  wire [RFIS_AW-1:0] base = (kind_now == K_D2H) ? RFIS_AW'(D2H_BASE) : '0;

  wire sending = (st == S_FETCH) || (st == S_SEND);
  wire collide = sending && (rx_sof_beat || !tx_tgt_abort_n);
  wire last    = (widx == WW'(FIS_DW - 1));
  wire accept  = (st == S_SEND) && !tx_ready_n;
  wire done    = accept && last && !collide;
  wire [SLOTS-1:0] clr_mask = done ? (SLOTS'(1) << cur) : '0;

  assign issue_pend = pend;
  assign tbl_addr   = {cur, widx};
  assign tx_data    = tbl_data;
  assign tx_valid_n = !(st == S_SEND);
  assign tx_eof_n   = !((st == S_SEND) && last);
  assign tx_abort_n = !abort_q;
  assign rx_ready_n = rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cur     <= '0;
      widx    <= '0;
      abort_q <= 1'b0;
      pend    <= '0;
    end else begin
      abort_q <= collide;
      pend    <= (pend & ~clr_mask) | issue_set;
      case (st)
        S_IDLE:
          if (any && rx_quiet) begin
            cur  <= pick;
            widx <= '0;
            st   <= S_FETCH;
          end
        S_FETCH: st <= collide ? S_WAIT : S_SEND;
        S_SEND:
          if (collide) st <= S_WAIT;
          else if (accept) begin
            if (last) st <= S_IDLE;
            else begin
              widx <= widx + 1'b1;
              st   <= S_FETCH;
            end
          end
        S_WAIT:
          if (rx_quiet) begin
            widx <= '0;
            st   <= S_FETCH;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_busy    <= 1'b0;
      rx_kind    <= K_NONE;
      rx_idx     <= '0;
      tag_ok     <= 1'b0;
      tag        <= '0;
      rfis_we    <= 1'b0;
      rfis_addr  <= '0;
      rfis_wdata <= '0;
      dma_start  <= 1'b0;
      dma_slot   <= '0;
    end else begin
      rfis_we    <= store;
      rfis_addr  <= base + RFIS_AW'(idx_now);
      rfis_wdata <= rx_data;
      dma_start  <= fire;
      if (fire) dma_slot <= tag_hit ? rx_data[SW-1:0] : tag;
      if (rx_drop) rx_busy <= 1'b0;
      else if (take) begin
        rx_busy <= !rx_eof_beat;
        rx_kind <= kind_now;
        rx_idx  <= (idx_now == RW'(REGION_DW)) ? idx_now : idx_now + 1'b1;
        if (tag_hit) begin
          tag    <= rx_data[SW-1:0];
          tag_ok <= 1'b1;
        end else if (rx_sof_beat) tag_ok <= 1'b0;
      end
    end
  end
endmodule

module ncq_fis_issuer_chk #(
  parameter int SLOTS     = 32,
  parameter int RFIS_AW   = 6,
  parameter int REGION_DW = 8,
  parameter int D2H_BASE  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [SLOTS-1:0]   issue_pend,
  input logic [31:0]        tx_data,
  input logic               tx_valid_n,
  input logic               tx_eof_n,
  input logic               tx_abort_n,
  input logic               tx_ready_n,
  input logic               tx_tgt_abort_n,
  input logic               rx_valid_n,
  input logic               rx_sof_n,
  input logic               rx_ready_n,
  input logic               rx_busy,
  input logic               rfis_we,
  input logic [RFIS_AW-1:0] rfis_addr,
  input logic               dma_start
);
  p_eof_with_valid_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_eof_n |-> !tx_valid_n);

  p_hold_until_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid_n && tx_ready_n && tx_tgt_abort_n && !(!rx_valid_n && !rx_sof_n))
    |=> (!tx_valid_n && $stable(tx_data) && $stable(tx_eof_n)));

  p_clear_after_eof_r2: assert property (@(posedge clk) disable iff (rst)
    (($past(issue_pend) & ~issue_pend) != '0)
    |-> ($past(!tx_eof_n) && $past(!tx_ready_n) && $past(tx_tgt_abort_n)));

  p_abort_on_collision_r5: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid_n && !rx_valid_n && !rx_sof_n) |=> (!tx_abort_n && tx_valid_n));

  p_abort_single_r5: assert property (@(posedge clk) disable iff (rst)
    !tx_abort_n |=> tx_abort_n);

  p_quiet_while_rx_r11: assert property (@(posedge clk) disable iff (rst)
    rx_busy |-> tx_valid_n);

  p_rx_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_ready_n);

  p_dma_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    dma_start |=> !dma_start);

  p_store_region_r8: assert property (@(posedge clk) disable iff (rst)
    rfis_we |-> ((rfis_addr < RFIS_AW'(REGION_DW)) ||
                 ((rfis_addr >= RFIS_AW'(D2H_BASE)) &&
                  (rfis_addr < RFIS_AW'(D2H_BASE + REGION_DW)))));
endmodule

bind ncq_fis_issuer ncq_fis_issuer_chk #(
  .SLOTS(SLOTS), .RFIS_AW(RFIS_AW), .REGION_DW(REGION_DW), .D2H_BASE(D2H_BASE)
) u_chk (
  .clk(clk), .rst(rst), .issue_pend(issue_pend), .tx_data(tx_data),
  .tx_valid_n(tx_valid_n), .tx_eof_n(tx_eof_n), .tx_abort_n(tx_abort_n),
  .tx_ready_n(tx_ready_n), .tx_tgt_abort_n(tx_tgt_abort_n),
  .rx_valid_n(rx_valid_n), .rx_sof_n(rx_sof_n), .rx_ready_n(rx_ready_n),
  .rx_busy(rx_busy), .rfis_we(rfis_we), .rfis_addr(rfis_addr),
  .dma_start(dma_start)
);

// File: tb/ncq_fis_issuer_test.sv
`timescale 1ns/1ps
module ncq_fis_issuer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] issue_set = '0;
  logic [31:0] issue_pend;
  logic [7:0]  tbl_addr;
  logic [31:0] tbl_data = '0;
  logic [31:0] tx_data;
  logic        tx_valid_n, tx_eof_n, tx_abort_n;
  logic        tx_ready_n = 1'b0;
  logic        tx_tgt_abort_n = 1'b1;
  logic [31:0] rx_data = '0;
  logic        rx_sof_n = 1'b1, rx_eof_n = 1'b1, rx_valid_n = 1'b1, rx_disc_n = 1'b1;
  logic        rx_ready_n;
  logic        rfis_we;
  logic [5:0]  rfis_addr;
  logic [31:0] rfis_wdata;
  logic        dma_start;
  logic [4:0]  dma_slot;

  int checks = 0;
  int bad = 0;
  int fr_cnt = 0;
  int fr_slot [0:63];
  int part = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  logic [4:0] mon_slot = '0;

  always #2 clk = ~clk;

  ncq_fis_issuer uut (
    .clk(clk), .rst(rst), .issue_set(issue_set), .issue_pend(issue_pend),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tx_data(tx_data),
    .tx_valid_n(tx_valid_n), .tx_eof_n(tx_eof_n), .tx_abort_n(tx_abort_n),
    .tx_ready_n(tx_ready_n), .tx_tgt_abort_n(tx_tgt_abort_n),
    .rx_data(rx_data), .rx_sof_n(rx_sof_n), .rx_eof_n(rx_eof_n),
    .rx_valid_n(rx_valid_n), .rx_disc_n(rx_disc_n), .rx_ready_n(rx_ready_n),
    .rfis_we(rfis_we), .rfis_addr(rfis_addr), .rfis_wdata(rfis_wdata),
    .dma_start(dma_start), .dma_slot(dma_slot)
  );

  always @(posedge clk) tbl_data <= 32'hC0DE0000 | 32'(tbl_addr);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] expw;
    cyc++;
    tx_ready_n = stall_en ? (cyc % 3 == 0) : 1'b0;
    if (rst) part = 0;
    else begin
      if (!tx_abort_n) part = 0;
      if (!tx_valid_n && !tx_ready_n) begin
        if (part == 0) mon_slot = tx_data[7:3];
        expw = 32'hC0DE0000 | 32'({mon_slot, 3'(part)});
        chk(tx_data == expw && (tx_eof_n == (part != 4)), "R4 word", {31'(tx_eof_n), tx_data}, {31'(part != 4), expw});
        if (!tx_eof_n) begin
          fr_slot[fr_cnt] = int'(mon_slot);
          fr_cnt++;
          part = 0;
        end else part++;
      end
    end
  end

  // {typ[8], 3'b0, tag[5], 2'b0, store, dma, len[4], 2'b0, base[6]}
  localparam logic [31:0] VEC [7] = '{
    {8'h41, 3'b0, 5'd5,  2'b0, 1'b1, 1'b1, 4'd7,  2'b0, 6'd0},
    {8'h34, 3'b0, 5'd0,  2'b0, 1'b1, 1'b0, 4'd5,  2'b0, 6'd16},
    {8'h41, 3'b0, 5'd31, 2'b0, 1'b1, 1'b1, 4'd10, 2'b0, 6'd0},
    {8'h27, 3'b0, 5'd0,  2'b0, 1'b0, 1'b0, 4'd5,  2'b0, 6'd0},
    {8'h41, 3'b0, 5'd0,  2'b0, 1'b1, 1'b0, 4'd1,  2'b0, 6'd0},
    {8'h5F, 3'b0, 5'd3,  2'b0, 1'b0, 1'b0, 4'd4,  2'b0, 6'd0},
    {8'h41, 3'b0, 5'd18, 2'b0, 1'b1, 1'b1, 4'd2,  2'b0, 6'd0}
  };

  function automatic logic [31:0] fword(input int i, input int k, input logic [7:0] typ, input logic [4:0] tg);
    if (k == 0) return {16'h5A00, 8'(i), typ};
    if (k == 1) return {16'h7700, 8'(i), 3'b0, tg};
    return 32'hD0000000 | 32'(i << 8) | 32'(k);
  endfunction

  task automatic rx_put(input logic [31:0] d, input bit sof, input bit eof, input bit disc);
    @(negedge clk);
    rx_data = d; rx_valid_n = 1'b0;
    rx_sof_n = !sof; rx_eof_n = !eof; rx_disc_n = !disc;
    @(posedge clk); #1;
  endtask

  task automatic rx_idle();
    @(negedge clk);
    rx_valid_n = 1'b1; rx_sof_n = 1'b1; rx_eof_n = 1'b1; rx_disc_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic wait_frames(input int n);
    for (int k = 0; k < 3000 && fr_cnt < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 100 && tx_valid_n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic issue(input logic [31:0] bits);
    @(negedge clk); issue_set = bits;
    @(negedge clk); issue_set = '0;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base_cnt;
    repeat (4) @(posedge clk);
    #1;
    chk(rx_ready_n == 1'b1, "R7 ready high in reset", rx_ready_n, 1);
    chk(tx_valid_n && tx_eof_n && tx_abort_n, "R1 tx idle in reset", {tx_valid_n, tx_eof_n, tx_abort_n}, 3'b111);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk(issue_pend == '0, "R1 pend", issue_pend, 0);
    chk(tx_valid_n && tx_eof_n && tx_abort_n, "R1 tx idle", {tx_valid_n, tx_eof_n, tx_abort_n}, 3'b111);
    chk(!rfis_we && !dma_start, "R1 rx outputs", {rfis_we, dma_start}, 0);
    chk(rx_ready_n == 1'b0, "R7 ready after reset", rx_ready_n, 0);

    // R8 / R9: receive vector table
    for (int i = 0; i < 7; i++) begin
      logic [7:0] typ; logic [4:0] tg; logic st_en, dm; int len; logic [5:0] bs;
      typ = VEC[i][31:24]; tg = VEC[i][20:16]; st_en = VEC[i][13];
      dm = VEC[i][12]; len = int'(VEC[i][11:8]); bs = VEC[i][5:0];
      for (int k = 0; k < len; k++) begin
        logic [31:0] w;
        w = fword(i, k, typ, tg);
        rx_put(w, k == 0, k == len - 1, 1'b0);
        if (st_en && k < 8)
          chk(rfis_we && rfis_addr == bs + 6'(k) && rfis_wdata == w, "R8 store",
              {rfis_we, rfis_addr, rfis_wdata}, {1'b1, bs + 6'(k), w});
        else
          chk(!rfis_we, "R8 no store", rfis_we, 0);
        if (k == len - 1) begin
          chk(dma_start == dm, "R9 dma start", dma_start, dm);
          if (dm) chk(dma_slot == tg, "R9 dma slot", dma_slot, tg);
        end else
          chk(!dma_start, "R9 no early start", dma_start, 0);
      end
      rx_idle();
      chk(!dma_start, "R9 single pulse", dma_start, 0);
    end

    // R10: disconnect mid-frame
    rx_put(fword(9, 0, 8'h41, 5'd6), 1'b1, 1'b0, 1'b0);
    rx_put(fword(9, 1, 8'h41, 5'd6), 1'b0, 1'b0, 1'b0);
    chk(rfis_we && rfis_addr == 6'd1, "R10 before disconnect", {rfis_we, rfis_addr}, {1'b1, 6'd1});
    rx_put(fword(9, 2, 8'h41, 5'd6), 1'b0, 1'b0, 1'b1);
    chk(!rfis_we, "R10 disconnect beat", rfis_we, 0);
    rx_put(fword(9, 3, 8'h41, 5'd6), 1'b0, 1'b1, 1'b0);
    chk(!rfis_we && !dma_start, "R10 after disconnect", {rfis_we, dma_start}, 0);
    rx_idle();
    chk(!dma_start, "R10 no dma", dma_start, 0);

    // R2 / R3 / R7: ascending service with stalls
    @(posedge clk); #1 stall_en = 1'b1;
    base_cnt = fr_cnt;
    issue(32'h0000_008A);
    chk(issue_pend == 32'h0000_008A || issue_pend == 32'h0000_008A, "R2 set", issue_pend, 32'h8A);
    wait_valid();
    chk(rx_ready_n == 1'b0, "R7 ready during tx", rx_ready_n, 0);
    wait_frames(base_cnt + 3);
    chk(fr_cnt == base_cnt + 3, "R3 frame count", fr_cnt, base_cnt + 3);
    chk(fr_slot[base_cnt] == 1, "R3 first slot", fr_slot[base_cnt], 1);
    chk(fr_slot[base_cnt + 1] == 3, "R3 second slot", fr_slot[base_cnt + 1], 3);
    chk(fr_slot[base_cnt + 2] == 7, "R3 third slot", fr_slot[base_cnt + 2], 7);
    repeat (2) @(posedge clk); #1;
    chk(issue_pend == '0, "R2 cleared", issue_pend, 0);
    stall_en = 1'b0;

    // R5 / R6 / R11: device frame collides with slot 2
    base_cnt = fr_cnt;
    issue(32'h0000_0004);
    wait_valid();
    rx_put(fword(20, 0, 8'h34, 5'd0), 1'b1, 1'b0, 1'b0);
    chk(!tx_abort_n && tx_valid_n, "R5 abort after sof", {tx_abort_n, tx_valid_n}, 2'b01);
    chk(issue_pend[2], "R2 kept after collision", issue_pend[2], 1);
    for (int k = 1; k < 5; k++) begin
      rx_put(fword(20, k, 8'h34, 5'd0), 1'b0, k == 4, 1'b0);
      chk(tx_valid_n && tx_abort_n, "R11 quiet during device frame", {tx_valid_n, tx_abort_n}, 2'b11);
    end
    rx_idle();
    wait_frames(base_cnt + 1);
    chk(fr_cnt == base_cnt + 1 && fr_slot[base_cnt] == 2, "R6 retried slot", fr_slot[base_cnt], 2);
    repeat (3) @(posedge clk); #1;
    chk(fr_cnt == base_cnt + 1, "R6 one frame", fr_cnt, base_cnt + 1);
    chk(issue_pend == '0, "R6 pend cleared", issue_pend, 0);

    // R5 / R6: target abort on slot 9
    base_cnt = fr_cnt;
    issue(32'h0000_0200);
    wait_valid();
    @(negedge clk) tx_tgt_abort_n = 1'b0;
    @(posedge clk); #1;
    chk(!tx_abort_n, "R5 abort after target abort", tx_abort_n, 0);
    chk(issue_pend[9], "R2 kept after target abort", issue_pend[9], 1);
    @(negedge clk) tx_tgt_abort_n = 1'b1;
    @(posedge clk); #1;
    chk(tx_abort_n, "R5 abort one cycle", tx_abort_n, 1);
    wait_frames(base_cnt + 1);
    chk(fr_cnt == base_cnt + 1 && fr_slot[base_cnt] == 9, "R6 target abort retry", fr_slot[base_cnt], 9);
    repeat (2) @(posedge clk); #1;
    chk(issue_pend == '0, "R2 cleared after retry", issue_pend, 0);

    // R11: issue while a device frame is in progress
    base_cnt = fr_cnt;
    rx_put(fword(21, 0, 8'h34, 5'd0), 1'b1, 1'b0, 1'b0);
    issue_set = 32'h0000_0040;
    rx_put(fword(21, 1, 8'h34, 5'd0), 1'b0, 1'b0, 1'b0);
    issue_set = '0;
    chk(issue_pend[6] && tx_valid_n, "R11 held off", {issue_pend[6], tx_valid_n}, 2'b11);
    rx_put(fword(21, 2, 8'h34, 5'd0), 1'b0, 1'b0, 1'b0);
    chk(tx_valid_n, "R11 held off mid-frame", tx_valid_n, 1);
    rx_put(fword(21, 3, 8'h34, 5'd0), 1'b0, 1'b1, 1'b0);
    chk(tx_valid_n, "R11 held off at eof", tx_valid_n, 1);
    rx_idle();
    wait_frames(base_cnt + 1);
    chk(fr_cnt == base_cnt + 1 && fr_slot[base_cnt] == 6, "R11 sent after frame", fr_slot[base_cnt], 6);

    summary();
  end
endmodule